// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

This block sits between a dataflow execution fabric and a simple memory port. Memory requests reach it in whatever order the fabric produces them. Each ordered request names the wave it belongs to, which is one dynamic instance of a loop-free region. It also carries three sequence numbers: its predecessor, itself and its successor. The block parks early arrivals in a small per-thread buffer and issues each one only after its predecessor has issued. This rebuilds program order at the memory port.

A thread has to be opened with a start command before any of its requests are honoured. A stop command closes the thread and discards anything it still has buffered. Each thread tracks its own expected wave and its last issued sequence number.

Unordered loads and stores skip the buffer and go straight to the memory port. No-op acknowledge requests take their place in the ordering chain but never reach memory. When a no-op's turn comes, the block returns a zero-valued response so software can use it as a sync point. Memory responses come back with the tag that was issued. The block forwards them to the requester when the tag's notify bit is set.

Top module: `wave_order_seq`

## Requirements
- R1: While reset is high and immediately after it, mem_req_valid, rsp_valid and err_no_ctx are 0, and every thread is closed.
- R2: Requests on the ordered path issue only in the order the sequence chain defines. Within the current wave, a request is eligible when its predecessor equals the last issued sequence number. The reserved predecessor 0 marks the first request of a wave. Sequence numbers of real requests are nonzero.
- R3: A successor value of all ones (15 by default) marks the end of a wave. Once that request issues, the thread moves to the next wave number and its last issued sequence returns to 0. Requests from later waves stay buffered until then.
- R4: A request of kind 2 (no-op acknowledge, kinds are 0 load, 1 store, 2 no-op) never produces a memory access. When its turn in the chain comes, rsp_valid pulses with data 0 and the tag {tid, wave, own sequence, notify=1}.
- R5: A load or store with req_unord=1 bypasses ordering and is placed on the memory port in the cycle after it is accepted, even while ordered requests of its thread are waiting.
- R6: The tag is packed from MSB down as {tid, wave, seq, notify}, with notify in bit 0. It is 1 for ordered loads and for all unordered accesses, and 0 for ordered stores. A memory response whose notify bit is set appears on rsp_* one cycle later with the same tag and data. Responses with notify clear are not forwarded.
- R7: Each thread keeps its own ordering state. A blocked thread does not stop another thread's eligible requests from issuing.
- R8: A start command opens a thread with wave 0, last sequence 0 and an empty buffer. A stop command closes it and discards its buffered requests.
- R9: A request for a thread with no open context is accepted and dropped. No memory access follows, and err_no_ctx is high for exactly the next cycle.
- R10: Each thread buffers up to 8 ordered requests. With 8 held, req_ready is low for further ordered requests to that thread.
- R11: While mem_req_ready is low, a pending memory request stays valid and keeps its fields unchanged. Unordered requests see req_ready low until the slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Context command strobe |
| cmd_stop | input | 1 | 0 opens a context, 1 closes it |
| cmd_tid | input | 1 | Thread targeted by the command |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted this cycle |
| req_tid | input | 1 | Request thread |
| req_kind | input | 2 | 0 load, 1 store, 2 no-op acknowledge |
| req_unord | input | 1 | Bypass ordering (loads and stores only) |
| req_wave | input | 4 | Wave number |
| req_pred | input | 4 | Predecessor sequence number |
| req_own | input | 4 | Own sequence number |
| req_succ | input | 4 | Successor sequence number |
| req_addr | input | 8 | Memory address |
| req_wdata | input | 16 | Store data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Write enable |
| mem_req_addr | output | 8 | Memory address |
| mem_req_wdata | output | 16 | Write data |
| mem_req_tag | output | 10 | Tag returned with the response |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_tag | input | 10 | Tag of the response |
| mem_rsp_data | input | 16 | Response data |
| rsp_valid | output | 1 | Response to requester valid |
| rsp_tag | output | 10 | Response tag |
| rsp_data | output | 16 | Response data |
| err_no_ctx | output | 1 | One-cycle pulse for a request dropped with no context |

## Verification
The assertions assume the memory returns at most one response per cycle and that each response tag is one the block issued earlier. They also assume the fabric sends each ordered sequence number only once per wave, so no two buffered entries of a thread can match at the same time. The stimulus follows these rules. Its memory model answers every accepted request exactly once, two cycles later, with the tag unchanged. Every wave it sends forms a single well-formed chain ending in the all-ones successor, except for entries that are parked on purpose so they never become eligible.

// File: rtl/wo_pkg.sv
package wo_pkg;
  parameter int TID_W  = 1;
  parameter int WAVE_W = 4;
  parameter int SEQ_W  = 4;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 16;

  localparam int TAG_W = TID_W + WAVE_W + SEQ_W + 1;
  localparam logic [SEQ_W-1:0] SEQ_START = '0;
  localparam logic [SEQ_W-1:0] SEQ_END   = '1;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_NOP   = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [WAVE_W-1:0] wave;
    logic [SEQ_W-1:0]  pred;
    logic [SEQ_W-1:0]  own_seq;
    logic [SEQ_W-1:0]  succ;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } entry_t;

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [WAVE_W-1:0] wave;
    logic [SEQ_W-1:0]  seq;
    logic              notify;
  } tag_t;
endpackage

// File: rtl/wo_thread_ctx.sv
module wo_thread_ctx
  import wo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cmd_open,
  input  logic   cmd_close,
  input  logic   wr_en,
  input  entry_t wr_data,
  input  logic   iss_en,
  output logic   ctx_open,
  output logic   buf_full,
  output logic   cand_valid,
  output entry_t cand
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  entry_t            ent_q [DEPTH];
  logic              open_q;
  logic [WAVE_W-1:0] wave_q;
  logic [SEQ_W-1:0]  last_q;
  logic [IDX_W-1:0]  free_idx, cand_idx;
  logic              free_ok;

  // lowest free slot
  always_comb begin
    free_idx = '0;
    free_ok  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IDX_W'(i);
        free_ok  = 1'b1;
      end
    end
  end

  // entry whose predecessor is the last issued sequence of the current wave
  always_comb begin
    cand_idx   = '0;
    cand_valid = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && ent_q[i].wave == wave_q && ent_q[i].pred == last_q) begin
        cand_idx   = IDX_W'(i);
        cand_valid = 1'b1;
      end
    end
  end

  assign cand     = ent_q[cand_idx];
  assign buf_full = !free_ok;
  assign ctx_open = open_q;

  // payload storage, no reset so it maps to plain memory
  always_ff @(posedge clk) begin
    if (wr_en) ent_q[free_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      vld_q  <= '0;
      wave_q <= '0;
      last_q <= SEQ_START;
    end else begin
      if (wr_en) vld_q[free_idx] <= 1'b1;
      if (iss_en) begin
        vld_q[cand_idx] <= 1'b0;
        if (cand.succ == SEQ_END) begin
          wave_q <= wave_q + 1'b1;
          last_q <= SEQ_START;
        end else begin
          last_q <= cand.own_seq;
        end
      end
      if (cmd_open) begin
        open_q <= 1'b1;
        vld_q  <= '0;
        wave_q <= '0;
        last_q <= SEQ_START;
      end
      if (cmd_close) begin
        open_q <= 1'b0;
        vld_q  <= '0;
      end
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !buf_full);
  assert_issue_eligible_R2: assert property (@(posedge clk) disable iff (rst)
    iss_en |-> cand_valid);
  assert_closed_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !open_q |-> (vld_q == '0));
endmodule

// File: rtl/wo_resp_stage.sv
module wo_resp_stage
  import wo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_rsp_valid,
  input  tag_t              mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              nop_fire,
  input  tag_t              nop_tag,
  output logic              rsp_valid,
  output tag_t              rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
    end else if (mem_rsp_valid) begin
      rsp_valid <= mem_rsp_tag.notify;
      rsp_tag   <= mem_rsp_tag;
      rsp_data  <= mem_rsp_data;
    end else if (nop_fire) begin
      rsp_valid <= 1'b1;
      rsp_tag   <= nop_tag;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  assert_nop_no_clash_R4: assert property (@(posedge clk) disable iff (rst)
    nop_fire |-> !mem_rsp_valid);
  assert_rsp_forward_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_tag.notify) |=> (rsp_valid && rsp_tag == $past(mem_rsp_tag)));
endmodule

// File: rtl/wave_order_seq.sv
module wave_order_seq
  import wo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_stop,
  input  logic [TID_W-1:0]  cmd_tid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [1:0]        req_kind,
  input  logic              req_unord,
  input  logic [WAVE_W-1:0] req_wave,
  input  logic [SEQ_W-1:0]  req_pred,
  input  logic [SEQ_W-1:0]  req_own,
  input  logic [SEQ_W-1:0]  req_succ,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic [TAG_W-1:0]  mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic [TAG_W-1:0]  mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_no_ctx
);
  localparam int NUM_THREADS = 2 ** TID_W;

  kind_e  in_kind;
  logic   is_unord, tid_open, slot_free, acc, unord_fire, ord_wr;
  entry_t in_ent;

  logic [NUM_THREADS-1:0] ctx_open, buf_full, cand_valid, can_iss, iss_vec;
  logic [NUM_THREADS-1:0] c_open, c_close;
  entry_t                 cand [NUM_THREADS];

  logic             found;
  logic [TID_W-1:0] sel_tid;
  entry_t           sel;
  logic             ord_mem, nop_fire;
  tag_t             nop_tag, rsp_tag_s;

  assign in_kind   = kind_e'(req_kind);
  assign is_unord  = req_unord && (in_kind != K_NOP);
  assign tid_open  = ctx_open[req_tid];
  assign slot_free = !mem_req_valid || mem_req_ready;
  assign req_ready = !tid_open ? 1'b1 : (is_unord ? slot_free : !buf_full[req_tid]);
  assign acc        = req_valid && req_ready;
  assign unord_fire = acc && tid_open && is_unord;
  assign ord_wr     = acc && tid_open && !is_unord;

  assign in_ent = '{kind: in_kind, wave: req_wave, pred: req_pred, own_seq: req_own,
                    succ: req_succ, addr: req_addr, wdata: req_wdata};

  genvar g;
  generate
    for (g = 0; g < NUM_THREADS; g++) begin : g_thr
      assign c_open[g]  = cmd_valid && !cmd_stop && (cmd_tid == TID_W'(g));
      assign c_close[g] = cmd_valid &&  cmd_stop && (cmd_tid == TID_W'(g));
      assign can_iss[g] = cand_valid[g] &&
                          ((cand[g].kind == K_NOP) ? !mem_rsp_valid : (slot_free && !unord_fire));
      assign iss_vec[g] = found && (sel_tid == TID_W'(g));

      wo_thread_ctx #(.DEPTH(DEPTH)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .cmd_open  (c_open[g]),
        .cmd_close (c_close[g]),
        .wr_en     (ord_wr && (req_tid == TID_W'(g))),
        .wr_data   (in_ent),
        .iss_en    (iss_vec[g]),
        .ctx_open  (ctx_open[g]),
        .buf_full  (buf_full[g]),
        .cand_valid(cand_valid[g]),
        .cand      (cand[g])
      );
    end
  endgenerate

  // fixed priority: lowest thread index wins
  always_comb begin
    found   = 1'b0;
    sel_tid = '0;
    for (int t = NUM_THREADS - 1; t >= 0; t--) begin
      if (can_iss[t]) begin
        found   = 1'b1;
        sel_tid = TID_W'(t);
      end
    end
  end

  assign sel      = cand[sel_tid];
  assign ord_mem  = found && (sel.kind != K_NOP);
  assign nop_fire = found && (sel.kind == K_NOP);
  assign nop_tag  = '{tid: sel_tid, wave: sel.wave, seq: sel.own_seq, notify: 1'b1};

  always_ff @(posedge clk) begin
    if (rst) mem_req_valid <= 1'b0;
    else if (slot_free) mem_req_valid <= unord_fire || ord_mem;
  end

  always_ff @(posedge clk) begin
    if (slot_free) begin
      if (unord_fire) begin
        mem_req_we    <= (in_kind == K_STORE);
        mem_req_addr  <= req_addr;
        mem_req_wdata <= req_wdata;
        mem_req_tag   <= {req_tid, req_wave, req_own, 1'b1};
      end else if (ord_mem) begin
        mem_req_we    <= (sel.kind == K_STORE);
        mem_req_addr  <= sel.addr;
        mem_req_wdata <= sel.wdata;
        mem_req_tag   <= {sel_tid, sel.wave, sel.own_seq, (sel.kind == K_LOAD)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_no_ctx <= 1'b0;
    else err_no_ctx <= acc && !tid_open;
  end

  wo_resp_stage u_rsp (
    .clk          (clk),
    .rst          (rst),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_tag  (tag_t'(mem_rsp_tag)),
    .mem_rsp_data (mem_rsp_data),
    .nop_fire     (nop_fire),
    .nop_tag      (nop_tag),
    .rsp_valid    (rsp_valid),
    .rsp_tag      (rsp_tag_s),
    .rsp_data     (rsp_data)
  );
  assign rsp_tag = rsp_tag_s;

  assert_hold_under_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag) && $stable(mem_req_we)));
  assert_one_issue_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iss_vec));
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ctx_open[req_tid]) |=> err_no_ctx);
  assert_unord_direct_R5: assert property (@(posedge clk) disable iff (rst)
    unord_fire |=> mem_req_valid);
endmodule

// File: tb/wave_order_seq_tb.sv
`timescale 1ns/1ps
module wave_order_seq_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_stop = 0;
  logic [0:0] cmd_tid = '0;
  logic req_valid = 0, req_unord = 0;
  logic [0:0] req_tid = '0;
  logic [1:0] req_kind = '0;
  logic [3:0] req_wave = '0, req_pred = '0, req_own = '0, req_succ = '0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, mem_req_valid, mem_req_we, rsp_valid, err_no_ctx;
  logic mem_req_ready = 1'b1;
  logic [7:0] mem_req_addr;
  logic [15:0] mem_req_wdata, rsp_data;
  logic [9:0] mem_req_tag, rsp_tag;
  logic mem_rsp_valid = 0;
  logic [9:0] mem_rsp_tag = '0;
  logic [15:0] mem_rsp_data = '0;

  int errors = 0, checks = 0;
  logic [7:0]  ml_addr [64];
  logic        ml_we   [64];
  logic [9:0]  ml_tag  [64];
  int ml_n = 0;
  logic [9:0]  rl_tag  [64];
  logic [15:0] rl_data [64];
  int rl_n = 0;
  logic pend = 0;
  logic [9:0] pend_tag = '0;
  logic [15:0] pend_data = '0;

  always #2 clk = ~clk;

  wave_order_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_stop(cmd_stop), .cmd_tid(cmd_tid),
    .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid), .req_kind(req_kind),
    .req_unord(req_unord), .req_wave(req_wave), .req_pred(req_pred), .req_own(req_own),
    .req_succ(req_succ), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .err_no_ctx(err_no_ctx)
  );

  // memory model: answers every accepted request two cycles later, logs traffic
  always @(negedge clk) begin
    #1;
    if (rst) begin
      mem_rsp_valid = 0;
      pend = 0;
    end else begin
      mem_rsp_valid = pend;
      mem_rsp_tag   = pend_tag;
      mem_rsp_data  = pend_data;
      pend = mem_req_valid && mem_req_ready;
      if (pend) begin
        if (ml_n < 64) begin
          ml_addr[ml_n] = mem_req_addr; ml_we[ml_n] = mem_req_we; ml_tag[ml_n] = mem_req_tag;
        end
        ml_n++;
        pend_tag  = mem_req_tag;
        pend_data = mem_req_we ? mem_req_wdata : {8'hA5, mem_req_addr};
      end
      if (rsp_valid) begin
        if (rl_n < 64) begin rl_tag[rl_n] = rsp_tag; rl_data[rl_n] = rsp_data; end
        rl_n++;
      end
    end
  end

  function automatic logic [9:0] mk_tag(input int tid, input int wave, input int seq);
    mk_tag = {tid[0], wave[3:0], seq[3:0], 1'b1};
  endfunction

  function automatic int find_rsp(input logic [9:0] tag);
    find_rsp = -1;
    for (int i = 0; i < rl_n && i < 64; i++) if (rl_tag[i] == tag) find_rsp = int'(rl_data[i]);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic stop, input int tid);
    @(negedge clk);
    cmd_valid = 1; cmd_stop = stop; cmd_tid = tid[0:0];
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic drive(input int tid, input int kind, input logic unord, input int wave,
                       input int pred, input int own, input int succ, input int addr,
                       input int wdata);
    req_tid = tid[0:0]; req_kind = kind[1:0]; req_unord = unord; req_wave = wave[3:0];
    req_pred = pred[3:0]; req_own = own[3:0]; req_succ = succ[3:0];
    req_addr = addr[7:0]; req_wdata = wdata[15:0]; req_valid = 1;
  endtask

  task automatic send(input int tid, input int kind, input logic unord, input int wave,
                      input int pred, input int own, input int succ, input int addr,
                      input int wdata);
    int n = 0;
    @(negedge clk);
    drive(tid, kind, unord, wave, pred, own, succ, addr, wdata);
    #1;
    while (!req_ready && n < 100) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk(mem_req_valid == 0, "R1 mem_req_valid after reset", mem_req_valid, 0);
    chk(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(err_no_ctx == 0, "R1 err after reset", err_no_ctx, 0);
    send(0, 0, 0, 0, 0, 1, 15, 8'h05, 0);
    chk(err_no_ctx == 1, "R9 err pulse on closed thread", err_no_ctx, 1);
    cyc(1);
    chk(err_no_ctx == 0, "R9 err lasts one cycle", err_no_ctx, 0);
    cyc(6);
    chk(ml_n == 0, "R1 closed after reset, request dropped (R9)", ml_n, 0);
  endtask

  task automatic t_order();
    cmd(0, 0);
    send(0, 0, 0, 0, 3, 4, 15, 8'h13, 0);
    send(0, 2, 0, 0, 2, 3, 4, 0, 0);
    send(0, 1, 0, 0, 1, 2, 3, 8'h11, 16'h1234);
    cyc(6);
    chk(ml_n == 0 && rl_n == 0, "R2 nothing issues before chain head", ml_n, 0);
    send(0, 0, 0, 0, 0, 1, 2, 8'h10, 0);
    cyc(20);
    chk(ml_n == 3, "R4 three accesses, no-op skips memory", ml_n, 3);
    chk(ml_addr[0] == 8'h10 && ml_we[0] == 0, "R2 first issued", ml_addr[0], 8'h10);
    chk(ml_addr[1] == 8'h11 && ml_we[1] == 1, "R2 second issued", ml_addr[1], 8'h11);
    chk(ml_addr[2] == 8'h13 && ml_we[2] == 0, "R2 third issued", ml_addr[2], 8'h13);
    chk(ml_tag[1] == 10'b0_0000_0010_0, "R6 ordered store tag notify clear", ml_tag[1], 10'h004);
    chk(rl_n == 3, "R6 ordered store response suppressed", rl_n, 3);
    chk(find_rsp(mk_tag(0, 0, 3)) == 0, "R4 no-op response data", find_rsp(mk_tag(0, 0, 3)), 0);
    chk(find_rsp(mk_tag(0, 0, 1)) == 16'hA510, "R6 load response data", find_rsp(mk_tag(0, 0, 1)), 16'hA510);
    chk(find_rsp(mk_tag(0, 0, 4)) == 16'hA513, "R6 last load response", find_rsp(mk_tag(0, 0, 4)), 16'hA513);
  endtask

  task automatic t_wave();
    send(0, 0, 0, 2, 0, 1, 15, 8'h30, 0);
    cyc(10);
    chk(ml_n == 3, "R3 later wave held", ml_n, 3);
    send(0, 0, 0, 1, 0, 1, 15, 8'h20, 0);
    cyc(15);
    chk(ml_n == 5, "R3 both waves issued", ml_n, 5);
    chk(ml_addr[3] == 8'h20, "R3 wave 1 first", ml_addr[3], 8'h20);
    chk(ml_addr[4] == 8'h30, "R3 wave 2 after wave end", ml_addr[4], 8'h30);
  endtask

  task automatic t_unord();
    send(0, 0, 0, 3, 5, 6, 7, 8'h60, 0);
    send(0, 1, 1, 3, 0, 9, 0, 8'h40, 16'hBEEF);
    cyc(10);
    chk(ml_n == 6 && ml_addr[5] == 8'h40 && ml_we[5] == 1, "R5 unordered store bypasses", ml_addr[5], 8'h40);
    chk(find_rsp(mk_tag(0, 3, 9)) == 16'hBEEF, "R6 unordered store returns value",
        find_rsp(mk_tag(0, 3, 9)), 16'hBEEF);
  endtask

  task automatic t_threads_full();
    cmd(0, 1);
    send(1, 0, 0, 0, 0, 1, 15, 8'h50, 0);
    cyc(10);
    chk(ml_n == 7 && ml_addr[6] == 8'h50, "R7 thread 1 issues while thread 0 blocked", ml_addr[6], 8'h50);
    for (int i = 0; i < 8; i++) send(1, 0, 0, 5, 0, i + 1, 15, 8'h70 + i, 0);
    @(negedge clk);
    drive(1, 0, 0, 5, 0, 9, 15, 8'h7F, 0);
    #1;
    chk(req_ready == 0, "R10 ready low with 8 buffered", req_ready, 0);
    req_valid = 0;
    cyc(4);
    chk(ml_n == 7, "R10 parked entries not issued", ml_n, 7);
    cmd(1, 1);
    send(1, 0, 0, 0, 0, 1, 15, 8'h52, 0);
    chk(err_no_ctx == 1, "R8 stopped thread drops requests", err_no_ctx, 1);
    cmd(0, 1);
    send(1, 0, 0, 0, 0, 1, 15, 8'h51, 0);
    cyc(15);
    chk(ml_n == 8 && ml_addr[7] == 8'h51, "R8 restart resets wave and empties buffer", ml_n, 8);
  endtask

  task automatic t_stall();
    @(negedge clk);
    mem_req_ready = 0;
    send(0, 0, 1, 4, 0, 2, 0, 8'h44, 0);
    cyc(5);
    chk(mem_req_valid == 1 && mem_req_addr == 8'h44, "R11 request held under stall", mem_req_addr, 8'h44);
    chk(ml_n == 8, "R11 no transfer while stalled", ml_n, 8);
    drive(0, 0, 1, 4, 0, 3, 0, 8'h45, 0);
    #1;
    chk(req_ready == 0, "R11 unordered ready low while slot full", req_ready, 0);
    req_valid = 0;
    @(negedge clk);
    mem_req_ready = 1;
    cyc(6);
    chk(ml_n == 9 && ml_addr[8] == 8'h44, "R11 transfer after release", ml_n, 9);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    cyc(4);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_order();
    t_wave();
    t_unord();
    t_threads_full();
    t_stall();
    report();
  end
endmodule